// File: doc/BRIEF.md
# Prioritized Exception Pending Resolver

This block holds the per-vector state of an exception controller: enable, pending and active bits for every vector, a programmable 8-bit priority for the configurable vectors, and the last seen level of each external interrupt line. Vectors 1 to 15 are internal system exceptions. Vectors 16 and up belong to external lines. Every clock the block scans all vectors. It finds the winning pending vector and the running priority of the active handlers, and it registers the result together with a request to the processor.

The processor side uses two handshakes. An acknowledge turns the winning pending vector into an active one. A completion ends the handler of a named vector. A software/internal pend port raises any vector. When the raised vector is a synchronous fault that cannot be taken, the port escalates it to HardFault. The mask state of the processor (fault mask, interrupt mask, base priority) arrives as plain inputs and feeds the execution priority used for escalation. Register decode and vector fetch belong to the surrounding logic.

Top module: `exc_resolver`

## Requirements
- R1: `pend_vec` names the enabled, pending vector with the numerically lowest priority. On equal priority the lower vector number wins. Vector 0 is never chosen, and `pend_vec` is 0 when no enabled vector is pending.
- R2: Vectors 1, 2 and 3 have the fixed priorities -3, -2 and -1, so they win over any programmable priority. After reset, vectors 2, 3, 11, 12, 14 and 15 are enabled and all other vectors are disabled. Every programmable priority resets to 0. `cfg_we` sets the enable and the priority of a vector numbered 4 or above, and it has no effect on lower vectors.
- R3: `irq_req` is 1 exactly when the winning pending priority is below the masked active priority. With no active vector, the active priority is 0x100, so any enabled pending vector requests.
- R4: The active priority is the lowest priority among active vectors. When it is non-negative, it is ANDed with the group mask `~0 << (prigroup+1)`.
- R5: A rising edge on `ext_line[k]` pends vector 16+k. A line that stays high does not pend the vector again.
- R6: When the handler of vector 16+k completes while `ext_line[k]` is still high, the vector becomes pending again.
- R7: An acknowledge taken while `irq_req` is 1 makes `pend_vec` active, clears its pending bit and reports it on `active_vec`.
- R8: A completion for a vector that is not active gives `cmpl_illegal`=1 one cycle later. Otherwise `cmpl_done`=1 and `cmpl_to_base` carries whether at most one vector was active before the clear. `rettobase` shows that same at-most-one condition continuously.
- R9: When vector v in 3..13 is pended while it is disabled, or while its priority is at or above the execution priority, vector 3 is pended in its place and the sticky `forced` flag is set.
- R10: An escalation that happens while the execution priority is negative pulses `lockup` for one cycle.
- R11: `isr_pending` is 1 when any vector numbered 16 or above is pending, whether it is enabled or not.
- R12: The running priority is -1 under `faultmask`, 0 under `primask`, `basepri` group-masked when nonzero, and 0x100 otherwise. The execution priority is the lower of the running priority and the active priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_line | input | NUM_EXT | External interrupt lines |
| cfg_we | input | 1 | Write enable and priority of `cfg_vec` |
| cfg_vec | input | VW | Vector being configured |
| cfg_en | input | 1 | Enable value to write |
| cfg_prio | input | 8 | Priority value to write |
| prigroup | input | 3 | Group-priority split point |
| faultmask | input | 1 | Processor fault mask |
| primask | input | 1 | Processor interrupt mask |
| basepri | input | 8 | Processor base priority (0 = off) |
| sw_pend | input | 1 | Pend request strobe |
| sw_vec | input | VW | Vector to pend |
| ack | input | 1 | Acknowledge of the pending vector |
| cmpl_valid | input | 1 | Handler completion strobe |
| cmpl_vec | input | VW | Vector whose handler completes |
| irq_req | output | 1 | Request to the processor |
| pend_vec | output | VW | Winning pending vector |
| active_vec | output | VW | Last acknowledged vector |
| rettobase | output | 1 | At most one vector active |
| isr_pending | output | 1 | Any external vector pending |
| cmpl_done | output | 1 | Completion accepted (pulse) |
| cmpl_illegal | output | 1 | Completion of inactive vector (pulse) |
| cmpl_to_base | output | 1 | At-most-one-active at completion |
| forced | output | 1 | Sticky escalation flag |
| lockup | output | 1 | Escalation under negative priority (pulse) |

## Verification
The first set of patterns pairs two external vectors under varied priorities and enables. One pattern ranks the first vector higher and one ranks the second higher; a third gives both the same priority, a fourth disables one of them and a fifth disables both. Together these separate a strict-less comparison from a less-or-equal one and show whether the enable gate works. Directed sequences then hold a line high across acknowledge and completion, which separates edge latching from level re-pending. The same active/pending pair is run under two `prigroup` settings, which shows that the group mask is applied. Faults are raised under a disabled vector, a blocking `basepri` and `faultmask`, which covers each way into escalation and lockup.

// File: rtl/exc_pkg.sv
// Shared types and helpers for the exception resolver.
// Assumes priorities fit a 10-bit signed value (-3 .. 0x100).
package exc_pkg;
    localparam int PW        = 10;
    localparam int FIRST_EXT = 16;
    localparam int V_HARD    = 3;
    localparam int FAULT_HI  = 13;

    typedef logic signed [PW-1:0] prio_t;

    localparam prio_t NO_EXC = 10'sd256;

    // Clear the subpriority bits of a non-negative priority.
    function automatic prio_t group_mask(prio_t p, logic [2:0] pg);
        logic [PW-1:0] m;
        m = {PW{1'b1}} << ({1'b0, pg} + 4'd1);
        if (p < 0) return p;
        return p & prio_t'(m);
    endfunction
endpackage

// File: rtl/exc_scan.sv
// Combinational scan over all vectors: winning pending vector, its
// priority, group-masked active priority and the summary flags.
// Assumes vector 0 is unused; only a strictly lower value replaces the best.
module exc_scan
    import exc_pkg::*;
#(
    parameter int N  = 32,
    parameter int VW = 5
) (
    input  logic [N-1:0]         pend,
    input  logic [N-1:0]         en,
    input  logic [N-1:0]         act,
    input  logic [N-1:0][PW-1:0] prio,
    input  logic [2:0]           pg,
    output logic [VW-1:0]        best_vec,
    output prio_t                best_prio,
    output prio_t                act_prio,
    output logic                 base_ok,
    output logic                 isr_any
);
    prio_t amin;

    // Linear minimum search over vectors 1..N-1.
    always_comb begin
        best_vec  = '0;
        best_prio = NO_EXC;
        amin      = NO_EXC;
        for (int i = 1; i < N; i++) begin
            if (pend[i] && en[i] && prio_t'(prio[i]) < best_prio) begin
                best_prio = prio_t'(prio[i]);
                best_vec  = VW'(i);
            end
            if (act[i] && prio_t'(prio[i]) < amin)
                amin = prio_t'(prio[i]);
        end
        act_prio = group_mask(amin, pg);
        base_ok  = ($countones(act) <= 1);
        isr_any  = |pend[N-1:FIRST_EXT];
    end
endmodule

// File: rtl/exc_exec_prio.sv
// Execution priority from the processor mask inputs and the active priority.
// Assumes the mask inputs are stable for the cycle they are used in.
module exc_exec_prio
    import exc_pkg::*;
(
    input  logic       faultmask,
    input  logic       primask,
    input  logic [7:0] basepri,
    input  logic [2:0] pg,
    input  prio_t      act_prio,
    output prio_t      exec_prio
);
    prio_t run;

    // Select the running priority, then take the lower of it and the active one.
    always_comb begin
        if (faultmask)           run = -10'sd1;
        else if (primask)        run = 10'sd0;
        else if (basepri != '0)  run = group_mask(prio_t'({2'b00, basepri}), pg);
        else                     run = NO_EXC;
        exec_prio = (run < act_prio) ? run : act_prio;
    end
endmodule

// File: rtl/exc_resolver.sv
// Exception state holder and resolver. It holds enable/pending/active bits,
// priorities and external line levels, and registers the scan result each cycle.
// Assumes ack is only meaningful while irq_req is high.
module exc_resolver
    import exc_pkg::*;
#(
    parameter int NUM_EXT = 16,
    localparam int N      = NUM_EXT + FIRST_EXT,
    localparam int VW     = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_line,
    input  logic               cfg_we,
    input  logic [VW-1:0]      cfg_vec,
    input  logic               cfg_en,
    input  logic [7:0]         cfg_prio,
    input  logic [2:0]         prigroup,
    input  logic               faultmask,
    input  logic               primask,
    input  logic [7:0]         basepri,
    input  logic               sw_pend,
    input  logic [VW-1:0]      sw_vec,
    input  logic               ack,
    input  logic               cmpl_valid,
    input  logic [VW-1:0]      cmpl_vec,
    output logic               irq_req,
    output logic [VW-1:0]      pend_vec,
    output logic [VW-1:0]      active_vec,
    output logic               rettobase,
    output logic               isr_pending,
    output logic               cmpl_done,
    output logic               cmpl_illegal,
    output logic               cmpl_to_base,
    output logic               forced,
    output logic               lockup
);
    localparam logic [N-1:0] EN_RST = N'((1 << 2) | (1 << 3) | (1 << 11) |
                                         (1 << 12) | (1 << 14) | (1 << 15));

    logic [N-1:0]         en_q, pend_q, act_q, en_n, pend_n, act_n;
    logic [NUM_EXT-1:0]   level_q, rise;
    logic [N-1:0][PW-1:0] eff;
    logic [N-1:0]         lvl_full;
    logic [VW-1:0]        s_vec;
    prio_t                s_prio, s_act, act_prio_q, exec_prio;
    logic                 s_base, s_isr;
    logic                 ack_ok, cmpl_in, cmpl_ok, sw_ok, esc, sw_fault;
    logic [VW-1:0]        sw_target;

    // Fixed priorities for vectors 0..3.
    assign eff[0] = NO_EXC;
    assign eff[1] = -10'sd3;
    assign eff[2] = -10'sd2;
    assign eff[3] = -10'sd1;

    // Programmable priority register per configurable vector.
    for (genvar g = 4; g < N; g++) begin : g_pri
        logic [7:0] pr_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                                  pr_q <= '0;
            else if (cfg_we && cfg_vec == VW'(g))        pr_q <= cfg_prio;
        end
        assign eff[g] = {2'b00, pr_q};
    end

    exc_scan #(.N(N), .VW(VW)) u_scan (
        .pend(pend_q), .en(en_q), .act(act_q), .prio(eff), .pg(prigroup),
        .best_vec(s_vec), .best_prio(s_prio), .act_prio(s_act),
        .base_ok(s_base), .isr_any(s_isr)
    );

    exc_exec_prio u_exec (
        .faultmask(faultmask), .primask(primask), .basepri(basepri),
        .pg(prigroup), .act_prio(act_prio_q), .exec_prio(exec_prio)
    );

    assign rise     = ext_line & ~level_q;
    assign lvl_full = {level_q, {FIRST_EXT{1'b0}}};
    assign ack_ok   = ack && irq_req && pend_q[pend_vec] && en_q[pend_vec];
    assign cmpl_in  = cmpl_valid && (32'(cmpl_vec) < N);
    assign cmpl_ok  = cmpl_in && act_q[cmpl_vec];
    assign sw_ok    = sw_pend && (32'(sw_vec) < N) && (sw_vec >= VW'(2));

    // Escalation decision for synchronous faults.
    always_comb begin
        sw_fault  = (sw_vec >= VW'(V_HARD)) && (sw_vec <= VW'(FAULT_HI));
        esc       = sw_ok && sw_fault &&
                    (prio_t'(eff[sw_vec]) >= exec_prio || !en_q[sw_vec]);
        sw_target = esc ? VW'(V_HARD) : sw_vec;
    end

    // Next state of the per-vector bits from all events of this cycle.
    always_comb begin
        en_n   = en_q;
        pend_n = pend_q | {rise, {FIRST_EXT{1'b0}}};
        act_n  = act_q;
        if (cfg_we && cfg_vec >= VW'(4) && 32'(cfg_vec) < N)
            en_n[cfg_vec] = cfg_en;
        if (ack_ok) begin
            act_n[pend_vec]  = 1'b1;
            pend_n[pend_vec] = 1'b0;
        end
        if (cmpl_ok) begin
            act_n[cmpl_vec] = 1'b0;
            if (lvl_full[cmpl_vec]) pend_n[cmpl_vec] = 1'b1;
        end
        if (sw_ok) pend_n[sw_target] = 1'b1;
    end

    // State registers and registered scan results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= EN_RST;  pend_q <= '0;  act_q <= '0;  level_q <= '0;
            irq_req <= 1'b0; pend_vec <= '0; active_vec <= '0;
            act_prio_q <= NO_EXC; rettobase <= 1'b1; isr_pending <= 1'b0;
            cmpl_done <= 1'b0; cmpl_illegal <= 1'b0; cmpl_to_base <= 1'b0;
            forced <= 1'b0; lockup <= 1'b0;
        end else begin
            en_q <= en_n;  pend_q <= pend_n;  act_q <= act_n;  level_q <= ext_line;
            irq_req     <= (s_prio < s_act);
            pend_vec    <= s_vec;
            act_prio_q  <= s_act;
            rettobase   <= s_base;
            isr_pending <= s_isr;
            if (ack_ok) active_vec <= pend_vec;
            cmpl_done    <= cmpl_ok;
            cmpl_illegal <= cmpl_valid && !cmpl_ok;
            cmpl_to_base <= cmpl_ok && s_base;
            if (esc) forced <= 1'b1;
            lockup       <= esc && (exec_prio < 0);
        end
    end

    // R1: a request always names a real vector.
    a_r1_no_vec0_request: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> pend_vec != '0);
    // R7: the acknowledged vector is active afterwards.
    a_r7_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && !(cmpl_valid && cmpl_vec == pend_vec)) |=> act_q[$past(pend_vec)]);
    // R8: completing an inactive vector is flagged.
    a_r8_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_in && !act_q[cmpl_vec]) |=> cmpl_illegal);
    // R8: two or more active handlers clear the base flag.
    a_r8_base_two_active: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(act_q) >= 2) |=> !rettobase);
    // R9: the escalation flag stays set.
    a_r9_forced_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        forced |=> forced);
    // R10: lockup only follows an escalation.
    a_r10_lockup_forced: assert property (@(posedge clk) disable iff (!rst_n)
        lockup |-> forced);
endmodule

// File: tb/exc_resolver_bench.sv
module exc_resolver_bench;
    localparam int VW = 5;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [15:0] ext_line = '0;
    logic cfg_we = 0, cfg_en = 0, faultmask = 0, primask = 0;
    logic sw_pend = 0, ack = 0, cmpl_valid = 0;
    logic [VW-1:0] cfg_vec = '0, sw_vec = '0, cmpl_vec = '0;
    logic [7:0] cfg_prio = '0, basepri = '0;
    logic [2:0] prigroup = '0;
    logic irq_req, rettobase, isr_pending, cmpl_done, cmpl_illegal, cmpl_to_base, forced, lockup;
    logic [VW-1:0] pend_vec, active_vec;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    exc_resolver u_exc_resolver (.*);

    typedef struct packed {
        logic [7:0] p0, p1; logic e0, e1; logic [4:0] vec; logic req;
    } row_t;
    localparam row_t ROWS [6] = '{
        '{8'h40, 8'h80, 1'b1, 1'b1, 5'd16, 1'b1},
        '{8'h80, 8'h40, 1'b1, 1'b1, 5'd17, 1'b1},
        '{8'h50, 8'h50, 1'b1, 1'b1, 5'd16, 1'b1},
        '{8'h40, 8'h80, 1'b0, 1'b1, 5'd17, 1'b1},
        '{8'h40, 8'h80, 1'b0, 1'b0, 5'd0,  1'b0},
        '{8'h00, 8'hFF, 1'b1, 1'b1, 5'd16, 1'b1}
    };

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask
    task automatic tick(int n); repeat (n) @(negedge clk); endtask
    task automatic cfg(int v, logic [7:0] p, logic e);
        cfg_we = 1; cfg_vec = VW'(v); cfg_prio = p; cfg_en = e; tick(1); cfg_we = 0;
    endtask
    task automatic pulse(logic [15:0] m); ext_line = m; tick(1); ext_line = '0; endtask
    task automatic do_ack; ack = 1; tick(1); ack = 0; endtask
    task automatic do_cmpl(int v);
        cmpl_valid = 1; cmpl_vec = VW'(v); tick(1); cmpl_valid = 0;
    endtask
    task automatic do_sw(int v); sw_pend = 1; sw_vec = VW'(v); tick(1); sw_pend = 0; endtask
    task automatic drain1; do_ack; tick(1); do_cmpl(int'(active_vec)); tick(1); endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3); rst_n = 1; tick(1);
        chk("R2 reset irq_req", irq_req, 0);
        chk("R1 reset pend_vec", pend_vec, 0);
        chk("R8 reset rettobase", rettobase, 1);
        chk("R11 reset isr_pending", isr_pending, 0);
        chk("R9 reset forced", forced, 0);

        // R1 R3: table walk over two external vectors 16 and 17.
        foreach (ROWS[i]) begin
            cfg(16, ROWS[i].p0, ROWS[i].e0);
            cfg(17, ROWS[i].p1, ROWS[i].e1);
            pulse(16'h0003); tick(2);
            chk($sformatf("R1 row%0d pend_vec", i), pend_vec, ROWS[i].vec);
            chk($sformatf("R3 row%0d irq_req", i), irq_req, ROWS[i].req);
            cfg(16, ROWS[i].p0, 1); cfg(17, ROWS[i].p1, 1); tick(2);
            drain1; drain1;
        end
        chk("R3 drained irq_req", irq_req, 0);

        // R5 R6: level held across ack and completion of vector 18.
        cfg(18, 8'h20, 1); ext_line[2] = 1; tick(2);
        chk("R5 edge pend_vec", pend_vec, 18);
        do_ack; tick(1);
        chk("R7 active_vec", active_vec, 18);
        chk("R5 held high no re-pend", isr_pending, 0);
        do_cmpl(18); tick(1);
        chk("R6 re-pend pend_vec", pend_vec, 18);
        chk("R6 re-pend irq_req", irq_req, 1);
        ext_line[2] = 0; do_ack; tick(1); do_cmpl(18); tick(1);
        chk("R6 low at completion", irq_req, 0);

        // R4 R8: nesting under two group settings.
        cfg(16, 8'h70, 1); cfg(17, 8'h50, 1);
        pulse(16'h0001); tick(2); do_ack; tick(1);
        pulse(16'h0002); tick(2);
        chk("R4 pg0 irq_req", irq_req, 1);
        chk("R4 pg0 pend_vec", pend_vec, 17);
        prigroup = 3'd6; tick(2);
        chk("R4 pg6 masked irq_req", irq_req, 0);
        prigroup = 3'd0; tick(2); do_ack; tick(1);
        chk("R8 two active rettobase", rettobase, 0);
        do_cmpl(17);
        chk("R8 done nested", cmpl_done, 1);
        chk("R8 nested to_base", cmpl_to_base, 0);
        tick(1); do_cmpl(16);
        chk("R8 last to_base", cmpl_to_base, 1);
        tick(1); do_cmpl(16);
        chk("R8 illegal completion", cmpl_illegal, 1);
        tick(2);

        // R9 R2: disabled fault 5 escalates; HardFault beats vector 16 at 0x00.
        cfg(16, 8'h00, 1);
        ext_line[0] = 1; sw_pend = 1; sw_vec = 5; tick(1); sw_pend = 0; ext_line[0] = 0;
        tick(2);
        chk("R9 escalated pend_vec", pend_vec, 3);
        chk("R9 forced set", forced, 1);
        drain1; tick(1);
        chk("R2 after hardfault pend_vec", pend_vec, 16);
        drain1;

        // R12: base priority blocks SVC at 0x80.
        cfg(11, 8'h80, 1); basepri = 8'h40; do_sw(11); tick(2);
        chk("R12 basepri escalation", pend_vec, 3);
        basepri = 8'h00; drain1;
        do_sw(11); tick(2);
        chk("R12 no mask no escalation", pend_vec, 11);
        drain1;

        // R10: fault mask forces lockup.
        faultmask = 1; do_sw(5);
        chk("R10 lockup pulse", lockup, 1);
        faultmask = 0; tick(1);
        chk("R10 lockup one cycle", lockup, 0);

        // R11: disabled external vector still counts.
        cfg(19, 8'h10, 0); pulse(16'h0008); tick(2);
        chk("R11 disabled isr_pending", isr_pending, 1);
        chk("R1 disabled not chosen", pend_vec, 3);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule